// File: doc/BRIEF.md
# Segmented Current-Steering Array Decoder

This block turns a binary code into the switch controls of a segmented current-steering converter array. The code is cut into three fields. The lowest field drives binary-weighted cell groups, with one control per bit. The middle field is turned into a thermometer code over a row of equal cells. The top field is also turned into a thermometer code, but those cells sit in a two-dimensional grid. The grid fills one row at a time, starting at the corner cell. Every cell in the unary fields has its own control, so a larger code never turns fewer cells on.

Each cell, binary or unary, has two controls. The positive control steers the cell's current to the output. The negative control steers it to the dump node. Both come from registers clocked on the same edge. When a cell changes side, the newly closing switch closes on the first edge. The opening switch opens one edge later. The cell therefore always has a path for its current and never stalls.

Top module: `seg_cs_dac_dec`

## Requirements
- R1: While reset is asserted, every positive control is 0 and every negative control is 1.
- R2: The three least significant code bits are the binary field. Once settled, `bin_pos[i]` equals code bit i. Bit i stands for 2^i unit cells.
- R3: Code bits 6..3 form the middle field, with value m. Once settled, `mid_pos` lines 0 to m-1 are on and the other lines of the 15 are off.
- R4: Code bits 11..7 form the top field, with value t. The 31 top cells have flat index n = row*8 + col, over 4 rows of 8. Position 31 is not built. Once settled, cell n is on exactly when n < t. Row 0 fills before row 1, and so on.
- R5: A cell that the new code enables shows `pos`=1 after the first rising edge that samples that code.
- R6: A cell that the new code disables shows `neg`=1 after the first edge. Its `pos` stays 1 until the second edge, so `pos` never falls while `neg` is 0.
- R7: For every cell, at every time, `pos` or `neg` is 1.
- R8: Code 0 held for two edges leaves every positive control 0. Code 4095 held for two edges leaves every positive control 1.
- R9: A code held for two edges gives `neg` = ~`pos` everywhere. It also gives a weighted on-count equal to the code: binary bits by weight, middle lines ×8, top cells ×128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all controls change on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| code_in | input | 12 | Binary code to convert |
| bin_pos | output | 3 | Binary group steered to output |
| bin_neg | output | 3 | Binary group steered to dump |
| mid_pos | output | 15 | Middle unary cells steered to output |
| mid_neg | output | 15 | Middle unary cells steered to dump |
| top_pos | output | 31 | Top grid cells (index row*8+col) steered to output |
| top_neg | output | 31 | Top grid cells steered to dump |

## Verification
The hardest case to reach from the ports is a cell that is still in its overlap window when the next code arrives. In that window both of the cell's switches are closed, and the next code reverses the cell's direction. To reach it, the stimulus changes the code on every edge: full-scale swings, a flip across mid-scale, and a long pseudo-random run. After that, codes are held for two edges so that the settled weight and the complement relation can be checked.

// File: rtl/dac_seg_pkg.sv
package dac_seg_pkg;

   // Number of unit cells a thermometer field of the given width drives.
   function automatic int unary_cells(input int w);
      return (1 << w) - 1;
   endfunction

   // Number of grid rows needed to hold the cells of a field.
   function automatic int grid_rows(input int cells, input int cols);
      return (cells + cols - 1) / cols;
   endfunction

endpackage

// File: rtl/seg_unary_dec.sv
module seg_unary_dec
   import dac_seg_pkg::*;
#(
   parameter int W    = 5,
   parameter int COLS = 8,
   parameter int N    = unary_cells(W)
) (
   input  logic [W-1:0] val,
   output logic [N-1:0] on
);

   generate
      if (COLS > 1 && COLS < N) begin : g_grid
         localparam int CB   = $clog2(COLS);
         localparam int ROWS = grid_rows(N, COLS);

         if ((1 << CB) != COLS) begin : g_bad_cols
            $error("seg_unary_dec: COLS must be a power of two");
         end

         logic [W-CB-1:0] row_sel;
         logic [CB-1:0]   col_sel;
         logic [ROWS-1:0] row_full;
         logic [ROWS-1:0] row_part;
         logic [COLS-1:0] col_lt;

         assign row_sel = val[W-1:CB];
         assign col_sel = val[CB-1:0];

         // Row decode: rows below the selected row are full, the selected row is partly filled.
         for (genvar r = 0; r < ROWS; r++) begin : g_row
            assign row_full[r] = int'(row_sel) > r;
            assign row_part[r] = int'(row_sel) == r;
         end

         // Column decode, shared by every row.
         for (genvar c = 0; c < COLS; c++) begin : g_col
            assign col_lt[c] = int'(col_sel) > c;
         end

         for (genvar r = 0; r < ROWS; r++) begin : g_cell_r
            for (genvar c = 0; c < COLS; c++) begin : g_cell_c
               if (r * COLS + c < N) begin : g_used
                  assign on[r*COLS+c] = row_full[r] | (row_part[r] & col_lt[c]);
               end
            end
         end
      end else begin : g_linear
         for (genvar i = 0; i < N; i++) begin : g_line
            assign on[i] = int'(val) > i;
         end
      end
   endgenerate

endmodule

// File: rtl/seg_mbb_drive.sv
module seg_mbb_drive #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] want,
   output logic [N-1:0] pos,
   output logic [N-1:0] neg
);

   logic [N-1:0] hist_q;
   logic [N-1:0] pos_q;
   logic [N-1:0] neg_q;

   // A side is held closed if either the current or the previous request selects it,
   // so the closing switch leads and the opening switch trails by one edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q <= '0;
         pos_q  <= '0;
         neg_q  <= '1;
      end else begin
         hist_q <= want;
         pos_q  <= want | hist_q;
         neg_q  <= ~want | ~hist_q;
      end
   end

   assign pos = pos_q;
   assign neg = neg_q;

endmodule

// File: rtl/seg_cs_dac_dec.sv
module seg_cs_dac_dec
   import dac_seg_pkg::*;
#(
   parameter int CODE_W   = 12,
   parameter int BIN_W    = 3,
   parameter int MID_W    = 4,
   parameter int TOP_W    = 5,
   parameter int MID_COLS = 0,
   parameter int TOP_COLS = 8,
   parameter int MID_N    = unary_cells(MID_W),
   parameter int TOP_N    = unary_cells(TOP_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] code_in,
   output logic [BIN_W-1:0]  bin_pos,
   output logic [BIN_W-1:0]  bin_neg,
   output logic [MID_N-1:0]  mid_pos,
   output logic [MID_N-1:0]  mid_neg,
   output logic [TOP_N-1:0]  top_pos,
   output logic [TOP_N-1:0]  top_neg
);

   localparam int MID_LO = BIN_W;
   localparam int TOP_LO = BIN_W + MID_W;

   generate
      if (CODE_W != BIN_W + MID_W + TOP_W) begin : g_bad_split
         $error("seg_cs_dac_dec: field widths must add up to CODE_W");
      end
      if (BIN_W < 1 || MID_W < 1 || TOP_W < 1) begin : g_bad_width
         $error("seg_cs_dac_dec: every field needs at least one bit");
      end
      if (MID_N != unary_cells(MID_W) || TOP_N != unary_cells(TOP_W)) begin : g_bad_cells
         $error("seg_cs_dac_dec: cell counts must match field widths");
      end
   endgenerate

   logic [BIN_W-1:0] bin_want;
   logic [MID_N-1:0] mid_want;
   logic [TOP_N-1:0] top_want;

   assign bin_want = code_in[BIN_W-1:0];

   seg_unary_dec #(.W(MID_W), .COLS(MID_COLS), .N(MID_N)) i_mid_dec (
      .val (code_in[MID_LO +: MID_W]),
      .on  (mid_want)
   );

   seg_unary_dec #(.W(TOP_W), .COLS(TOP_COLS), .N(TOP_N)) i_top_dec (
      .val (code_in[TOP_LO +: TOP_W]),
      .on  (top_want)
   );

   seg_mbb_drive #(.N(BIN_W)) i_bin_drv (
      .clk (clk), .rst_n (rst_n), .want (bin_want), .pos (bin_pos), .neg (bin_neg)
   );

   seg_mbb_drive #(.N(MID_N)) i_mid_drv (
      .clk (clk), .rst_n (rst_n), .want (mid_want), .pos (mid_pos), .neg (mid_neg)
   );

   seg_mbb_drive #(.N(TOP_N)) i_top_drv (
      .clk (clk), .rst_n (rst_n), .want (top_want), .pos (top_pos), .neg (top_neg)
   );

endmodule

// File: rtl/seg_cs_dac_dec_chk.sv
module seg_cs_dac_dec_chk #(
   parameter int CODE_W = 12,
   parameter int BIN_W  = 3,
   parameter int MID_W  = 4,
   parameter int MID_N  = 15,
   parameter int TOP_N  = 31
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CODE_W-1:0] code_in,
   input logic [BIN_W-1:0]  bin_pos,
   input logic [BIN_W-1:0]  bin_neg,
   input logic [MID_N-1:0]  mid_pos,
   input logic [MID_N-1:0]  mid_neg,
   input logic [TOP_N-1:0]  top_pos,
   input logic [TOP_N-1:0]  top_neg
);

   logic [1:0] age_q;
   logic       armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           age_q <= '0;
      else if (age_q != 2'd3) age_q <= age_q + 2'd1;
   end
   assign armed = (age_q == 2'd3);

   int weight;
   always_comb begin
      weight = int'(bin_pos) + ($countones(mid_pos) << BIN_W)
               + ($countones(top_pos) << (BIN_W + MID_W));
   end

   // R7
   never_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((bin_pos | bin_neg) == '1) && ((mid_pos | mid_neg) == '1) && ((top_pos | top_neg) == '1));

   // R6
   break_after_make_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((($past(top_pos) & ~top_pos) & ~$past(top_neg)) == '0) &&
      ((($past(mid_pos) & ~mid_pos) & ~$past(mid_neg)) == '0) &&
      ((($past(bin_pos) & ~bin_pos) & ~$past(bin_neg)) == '0));

   // R3
   mid_therm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((({1'b0, mid_pos} + 1'b1) & {1'b0, mid_pos}) == '0));

   // R4
   top_therm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((({1'b0, top_pos} + 1'b1) & {1'b0, top_pos}) == '0));

   // R9
   held_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(code_in) == $past(code_in, 2)) |->
         (weight == int'($past(code_in)) && bin_neg == ~bin_pos &&
          mid_neg == ~mid_pos && top_neg == ~top_pos));

endmodule

bind seg_cs_dac_dec seg_cs_dac_dec_chk #(
   .CODE_W (CODE_W), .BIN_W (BIN_W), .MID_W (MID_W), .MID_N (MID_N), .TOP_N (TOP_N)
) i_chk (
   .clk (clk), .rst_n (rst_n), .code_in (code_in),
   .bin_pos (bin_pos), .bin_neg (bin_neg),
   .mid_pos (mid_pos), .mid_neg (mid_neg),
   .top_pos (top_pos), .top_neg (top_neg)
);

// File: tb/test_seg_cs_dac_dec.sv
`timescale 1ns/1ps
module test_seg_cs_dac_dec;

   localparam int CW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [CW-1:0] code_in = '0;
   logic [2:0]    bin_pos, bin_neg;
   logic [14:0]   mid_pos, mid_neg;
   logic [30:0]   top_pos, top_neg;

   int total = 0;
   int bad = 0;
   int c0 = 0;   // code sampled one edge earlier
   int c1 = 0;   // code sampled at the latest edge
   bit done = 1'b0;

   always #5 clk = ~clk;

   seg_cs_dac_dec i_seg_cs_dac_dec (
      .clk (clk), .rst_n (rst_n), .code_in (code_in),
      .bin_pos (bin_pos), .bin_neg (bin_neg),
      .mid_pos (mid_pos), .mid_neg (mid_neg),
      .top_pos (top_pos), .top_neg (top_neg)
   );

   function automatic logic [63:0] therm(input int v);
      logic [63:0] r = '0;
      for (int i = 0; i < 64; i++) if (i < v) r[i] = 1'b1;
      return r;
   endfunction

   function automatic logic [63:0] ones(input int n);
      return therm(n);
   endfunction

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h (c1=%0d c0=%0d)", tag, got, exp, c1, c0);
      end
   endtask

   task automatic compare_all();
      logic [63:0] eb, em, et;
      int w;
      eb = 64'((c1 | c0) & 7);
      em = therm((c1 >> 3) & 15) | therm((c0 >> 3) & 15);
      et = therm((c1 >> 7) & 31) | therm((c0 >> 7) & 31);
      chk("R2 bin_pos", 64'(bin_pos), eb);
      chk("R3 mid_pos", 64'(mid_pos), em);
      chk("R4 top_pos", 64'(top_pos), et);
      chk("R6 bin_neg", 64'(bin_neg), 64'((~c1 | ~c0) & 7));
      chk("R6 mid_neg", 64'(mid_neg), (~therm((c1 >> 3) & 15) | ~therm((c0 >> 3) & 15)) & ones(15));
      chk("R6 top_neg", 64'(top_neg), (~therm((c1 >> 7) & 31) | ~therm((c0 >> 7) & 31)) & ones(31));
      chk("R7 no open pair", {bin_pos | bin_neg, mid_pos | mid_neg, top_pos | top_neg}, ones(49));
      if (c0 == c1) begin
         w = int'(bin_pos) + 8 * $countones(mid_pos) + 128 * $countones(top_pos);
         chk("R9 held weight", 64'(w), 64'(c1));
      end
   endtask

   task automatic tick(input int code);
      code_in = CW'(code);
      @(posedge clk);
      c0 = c1;
      c1 = code;
      @(negedge clk);
      compare_all();
   endtask

   initial begin
      int unsigned s = 32'h1234_5678;
      repeat (3) @(negedge clk);
      // R1: controls in reset
      chk("R1 pos in reset", {bin_pos, mid_pos, top_pos}, 64'd0);
      chk("R1 neg in reset", {bin_neg, mid_neg, top_neg}, ones(49));
      rst_n = 1'b1;

      tick(0); tick(0);
      chk("R8 code 0 all off", {bin_pos, mid_pos, top_pos}, 64'd0);

      // full-scale step and release
      tick(4095);
      chk("R5 all on after first edge", {bin_pos, mid_pos, top_pos}, ones(49));
      tick(4095);
      chk("R8 code 4095 all on", {bin_pos, mid_pos, top_pos}, ones(49));
      tick(0);
      chk("R6 pos held one more edge", {bin_pos, mid_pos, top_pos}, ones(49));
      chk("R6 neg closed first edge", {bin_neg, mid_neg, top_neg}, ones(49));
      tick(0);
      chk("R6 pos open second edge", {bin_pos, mid_pos, top_pos}, 64'd0);

      // R4: row fill order in top grid (t=9 fills row 0 and col 0 of row 1)
      tick(9 << 7); tick(9 << 7);
      chk("R4 row-major fill", 64'(top_pos), 64'h3FF >> 1);

      // mid-scale flip, both directions, every edge
      for (int k = 0; k < 6; k++) tick((k % 2 == 0) ? 2047 : 2048);
      tick(2048); tick(2047); tick(2047);

      // each field alone across its range
      for (int v = 0; v < 8; v++) begin tick(v); tick(v); end
      for (int v = 0; v < 16; v++) begin tick(v << 3); tick(v << 3); end
      for (int v = 0; v < 32; v++) begin tick(v << 7); tick(v << 7); end

      // pseudo-random codes, changing every edge, with occasional holds
      for (int k = 0; k < 600; k++) begin
         s = s * 32'd1103515245 + 32'd12345;
         tick(int'((s >> 8) & 32'hFFF));
         if (s[3]) tick(c1);
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog R1 expired got=running exp=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule